// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This block sits on the device side of a memory interface and runs the sequence that trims the output driver's pull-up and pull-down strengths. An external controller writes a three-bit calibration field through the extended mode register path. The block answers with one of three actions. It parks the data, strobe and complementary strobe pins at fixed levels so the controller can measure the driver. It collects a four-beat burst and turns it into step commands for the two strength codes. Or it reloads both codes with their default value. The block does not measure impedance; the external side compares levels and decides which way to step.

The override controls and the two strength codes are brought out as plain signals so that the pad ring can apply them. The block recognises a new calibration action only from the idle state, so the controller must write the exit code before it switches between actions. The pad logic registers each data beat once and flags it with a beat-valid pulse. Every lane carries the same value, and a beat reads as 1 only when all lanes are high.

Top module: `drv_imp_cal_ctrl`

## Requirements
- R1: After reset both strength codes hold the default value 8, the override enable is low and the burst error flag is low.
- R2: The calibration field is decoded as 000 exit, 001 drive-high, 010 drive-low, 100 adjust and 111 default; the codes 011, 101 and 110 are ignored and change neither the outputs nor the codes.
- R3: TOIT cycles after a drive-high write is accepted, the override enable rises with every data lane high, the true strobe high and the complementary strobe low.
- R4: TOIT cycles after a drive-low write is accepted, the override enable rises with every data lane low, the true strobe low and the complementary strobe high.
- R5: Forced levels persist until an exit write, and the override enable is low in the cycle after the exit. A drive, adjust or default write that arrives while any action other than idle is active is ignored.
- R6: In adjust mode, beat-valid pulses in the first WL cycles after entry are ignored. After that window the next four beats are captured, and a beat reads as 1 only when every data lane is high.
- R7: Beats 0 and 1 form the pull-up command and beats 2 and 3 form the pull-down command, with the earlier beat as the upper bit: 00 holds, 01 steps up by one and 10 steps down by one. The codes change in the cycle after the fourth beat, and only one burst is taken per adjust session.
- R8: Each 4-bit code saturates: a step up at 15 or a step down at 0 leaves it unchanged.
- R9: If either command field is 11, both codes stay unchanged.
- R10: A default write from idle reloads both codes with 8 in the following cycle.
- R11: An adjust write while the burst-length-4 configuration input is low raises the error flag and the burst is ignored; the flag clears with the exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_wr | input | 1 | Extended mode register write strobe |
| mrs_mode | input | 3 | Calibration field of the register write |
| bl4_cfg | input | 1 | High when a burst length of 4 is configured |
| dq_in | input | DQ_W | Registered data lanes, one beat per valid pulse |
| dq_beat_vld | input | 1 | Strobe-qualified beat valid |
| pu_code | output | CODE_W | Pull-up strength code |
| pd_code | output | CODE_W | Pull-down strength code |
| ovr_en | output | 1 | Output override enable |
| dq_ovr | output | DQ_W | Forced data lane levels |
| dqs_ovr | output | 1 | Forced true strobe level |
| dqs_n_ovr | output | 1 | Forced complementary strobe level |
| bl_err | output | 1 | Burst length error during adjust |

## Verification
A corrupted mode state shows at the override pins no later than TOIT cycles after the next drive write, or as a forced level that should have dropped in the cycle after exit. A miscounted write-latency window or beat counter misaligns the burst, so a code steps the wrong way or the wrong code steps. That error is visible in the cycle after the fourth beat. A saturation or reserved-field fault shows only at the code limits or on 11 patterns, so the stimulus drives both codes to each end and mixes reserved fields into the random bursts.

// File: rtl/drv_imp_cal_pkg.sv
package drv_imp_cal_pkg;

    typedef enum logic [2:0] {
        MODE_EXIT = 3'b000,
        MODE_DRV1 = 3'b001,
        MODE_DRV0 = 3'b010,
        MODE_ADJ  = 3'b100,
        MODE_DFLT = 3'b111
    } cal_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRV1,
        ST_DRV0,
        ST_ADJ,
        ST_ADJ_DONE
    } cal_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DN   = 2'b10,
        STEP_RSV  = 2'b11
    } step_e;

    typedef struct packed {
        logic       vld;
        logic [3:0] word;
    } burst_cmd_t;

    function automatic int sat_step(input int v, input step_e s, input int top);
        if (s == STEP_UP && v < top) return v + 1;
        if (s == STEP_DN && v > 0)   return v - 1;
        return v;
    endfunction

endpackage

// File: rtl/drv_imp_cal_fsm.sv
module drv_imp_cal_fsm
    import drv_imp_cal_pkg::*;
#(
    parameter int TOIT = 3,
    parameter int WL   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mrs_wr,
    input  logic [2:0] mrs_mode,
    input  logic       bl4_cfg,
    input  logic       cmd_vld,
    output logic       cap_en,
    output logic       reload,
    output logic       ovr_en,
    output logic       ovr_hi,
    output logic       bl_err
);
    localparam int MAXW = (TOIT > WL) ? TOIT : WL;
    localparam int CW   = $clog2(MAXW + 2);
    localparam logic [CW-1:0] TOIT_C = CW'(TOIT);
    localparam logic [CW-1:0] WL_C   = CW'(WL);

    cal_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          err_q, err_d;
    logic [CW-1:0] lim;

    assign lim = (st_q == ST_ADJ) ? WL_C : TOIT_C;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        err_d  = err_q;
        reload = 1'b0;
        if (mrs_wr && mrs_mode == MODE_EXIT) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            err_d = 1'b0;
        end else if (mrs_wr && st_q == ST_IDLE) begin
            case (mrs_mode)
                MODE_DRV1: begin st_d = ST_DRV1; cnt_d = '0; end
                MODE_DRV0: begin st_d = ST_DRV0; cnt_d = '0; end
                MODE_ADJ:  begin st_d = ST_ADJ;  cnt_d = '0; err_d = !bl4_cfg; end
                MODE_DFLT: reload = 1'b1;
                default:   ;
            endcase
        end else begin
            if (st_q != ST_IDLE && cnt_q < lim) cnt_d = cnt_q + 1'b1;
            if (cmd_vld) st_d = ST_ADJ_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            err_q <= err_d;
        end
    end

    assign ovr_en = (st_q == ST_DRV1 || st_q == ST_DRV0) && cnt_q == TOIT_C;
    assign ovr_hi = (st_q == ST_DRV1);
    assign cap_en = (st_q == ST_ADJ) && cnt_q == WL_C && !err_q;
    assign bl_err = err_q;

    // R5: an exit write drops the override and the error flag
    a_r5_exit_clears: assert property (@(posedge clk) disable iff (rst)
        (mrs_wr && mrs_mode == 3'b000) |=> (!ovr_en && !bl_err));

    // R5: forced levels stay until a register write arrives
    a_r5_hold_levels: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && !mrs_wr) |=> ovr_en);

    // R7: capture closes once the burst has been taken
    a_r7_one_burst: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !mrs_wr) |=> !cap_en);

    // R11: the error flag only exists inside an adjust session
    a_r11_err_scope: assert property (@(posedge clk) disable iff (rst)
        bl_err |-> (st_q == ST_ADJ || st_q == ST_ADJ_DONE));
endmodule

// File: rtl/drv_imp_cal_burst.sv
module drv_imp_cal_burst
    import drv_imp_cal_pkg::*;
#(
    parameter int DQ_W  = 8,
    parameter int BEATS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_en,
    input  logic            beat_vld,
    input  logic [DQ_W-1:0] dq_in,
    output burst_cmd_t      cmd
);
    localparam int BW = $clog2(BEATS);

    logic [BW-1:0]    beat_q;
    logic [BEATS-2:0] bits_q;
    logic             bit_now;
    logic             take;

    assign bit_now = &dq_in;
    assign take    = cap_en && beat_vld;

    always_ff @(posedge clk) begin
        if (rst || !cap_en) begin
            beat_q <= '0;
            bits_q <= '0;
        end else if (take) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q != BW'(BEATS - 1)) bits_q[beat_q] <= bit_now;
        end
    end

    assign cmd.vld  = take && beat_q == BW'(BEATS - 1);
    assign cmd.word = {bit_now, bits_q};

    // R6: a burst command is produced only while capture is open
    a_r6_cap_window: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> (beat_q == '0));
endmodule

// File: rtl/drv_imp_cal_strength.sv
module drv_imp_cal_strength
    import drv_imp_cal_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int DEF_CODE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd,
    input  logic              reload,
    output logic [CODE_W-1:0] pu_code,
    output logic [CODE_W-1:0] pd_code
);
    localparam int NCH = 2;
    localparam int TOP = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] DEF_C = CODE_W'(DEF_CODE);

    step_e             fld [NCH];
    logic [CODE_W-1:0] code_q [NCH];
    logic              rsv;

    assign rsv = (fld[0] == STEP_RSV) || (fld[1] == STEP_RSV);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign fld[k] = step_e'({cmd.word[2*k], cmd.word[2*k+1]});

        always_ff @(posedge clk) begin
            if (rst || reload)
                code_q[k] <= DEF_C;
            else if (cmd.vld && !rsv)
                code_q[k] <= CODE_W'(sat_step(int'(code_q[k]), fld[k], TOP));
        end

        // R8: a step up at the top limit leaves the code at the limit
        a_r8_sat_top: assert property (@(posedge clk) disable iff (rst)
            (cmd.vld && !reload && !rsv && fld[k] == STEP_UP &&
             code_q[k] == CODE_W'(TOP)) |=> code_q[k] == CODE_W'(TOP));

        // R8: a step down at zero leaves the code at zero
        a_r8_sat_bot: assert property (@(posedge clk) disable iff (rst)
            (cmd.vld && !reload && !rsv && fld[k] == STEP_DN &&
             code_q[k] == '0) |=> code_q[k] == '0);

        // R9: no accepted command and no reload keeps the code
        a_r9_hold: assert property (@(posedge clk) disable iff (rst)
            (!reload && !(cmd.vld && !rsv)) |=> $stable(code_q[k]));

        // R10: a reload lands on the default value
        a_r10_reload: assert property (@(posedge clk) disable iff (rst)
            reload |=> code_q[k] == DEF_C);
    end

    assign pu_code = code_q[0];
    assign pd_code = code_q[1];
endmodule

// File: rtl/drv_imp_cal_ctrl.sv
module drv_imp_cal_ctrl
    import drv_imp_cal_pkg::*;
#(
    parameter int DQ_W     = 8,
    parameter int CODE_W   = 4,
    parameter int DEF_CODE = 8,
    parameter int TOIT     = 3,
    parameter int WL       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_wr,
    input  logic [2:0]        mrs_mode,
    input  logic              bl4_cfg,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              dq_beat_vld,
    output logic [CODE_W-1:0] pu_code,
    output logic [CODE_W-1:0] pd_code,
    output logic              ovr_en,
    output logic [DQ_W-1:0]   dq_ovr,
    output logic              dqs_ovr,
    output logic              dqs_n_ovr,
    output logic              bl_err
);
    logic       cap_en;
    logic       reload;
    logic       ovr_hi;
    burst_cmd_t cmd;

    drv_imp_cal_fsm #(.TOIT(TOIT), .WL(WL)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mrs_wr   (mrs_wr),
        .mrs_mode (mrs_mode),
        .bl4_cfg  (bl4_cfg),
        .cmd_vld  (cmd.vld),
        .cap_en   (cap_en),
        .reload   (reload),
        .ovr_en   (ovr_en),
        .ovr_hi   (ovr_hi),
        .bl_err   (bl_err)
    );

    drv_imp_cal_burst #(.DQ_W(DQ_W), .BEATS(4)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .beat_vld (dq_beat_vld),
        .dq_in    (dq_in),
        .cmd      (cmd)
    );

    drv_imp_cal_strength #(.CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) u_str (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .reload  (reload),
        .pu_code (pu_code),
        .pd_code (pd_code)
    );

    assign dq_ovr    = {DQ_W{ovr_en & ovr_hi}};
    assign dqs_ovr   = ovr_en & ovr_hi;
    assign dqs_n_ovr = ovr_en & ~ovr_hi;

    // R3 R4: the two strobe levels are complementary while forced
    a_r3_strobe_pair: assert property (@(posedge clk) disable iff (rst)
        ovr_en |-> (dqs_ovr != dqs_n_ovr) && (dq_ovr == {DQ_W{dqs_ovr}}));
endmodule

// File: tb/drv_imp_cal_ctrl_tb_top.sv
module drv_imp_cal_ctrl_tb_top;
    localparam int DQ_W = 8;
    localparam int CW   = 4;
    localparam int DEF  = 8;
    localparam int TOIT = 3;
    localparam int WL   = 5;
    localparam int TOP  = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mrs_wr = 1'b0;
    logic [2:0]    mrs_mode = 3'b000;
    logic          bl4_cfg = 1'b1;
    logic [DQ_W-1:0] dq_in = '0;
    logic          dq_beat_vld = 1'b0;
    logic [CW-1:0] pu_code, pd_code;
    logic          ovr_en, dqs_ovr, dqs_n_ovr, bl_err;
    logic [DQ_W-1:0] dq_ovr;

    int n_chk = 0;
    int n_bad = 0;
    int exp_pu = DEF;
    int exp_pd = DEF;
    bit done = 1'b0;

    always #2 clk = ~clk;

    drv_imp_cal_ctrl #(.DQ_W(DQ_W), .CODE_W(CW), .DEF_CODE(DEF), .TOIT(TOIT), .WL(WL)) dut_i (
        .clk(clk), .rst(rst), .mrs_wr(mrs_wr), .mrs_mode(mrs_mode), .bl4_cfg(bl4_cfg),
        .dq_in(dq_in), .dq_beat_vld(dq_beat_vld), .pu_code(pu_code), .pd_code(pd_code),
        .ovr_en(ovr_en), .dq_ovr(dq_ovr), .dqs_ovr(dqs_ovr), .dqs_n_ovr(dqs_n_ovr),
        .bl_err(bl_err)
    );

    function automatic int step_model(input int v, input int f);
        if (f == 1 && v < TOP) return v + 1;
        if (f == 2 && v > 0)   return v - 1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mrs(input logic [2:0] m);
        mrs_wr = 1'b1;
        mrs_mode = m;
        tick();
        mrs_wr = 1'b0;
        mrs_mode = 3'($urandom);
    endtask

    task automatic chk_codes(input string req);
        chk(int'(pu_code) == exp_pu, {req, " pull-up code"}, int'(pu_code), exp_pu);
        chk(int'(pd_code) == exp_pd, {req, " pull-down code"}, int'(pd_code), exp_pd);
    endtask

    task automatic chk_levels(input string req, input bit hi);
        chk(ovr_en == 1'b1, {req, " override enable"}, int'(ovr_en), 1);
        chk(dq_ovr == {DQ_W{hi}}, {req, " data lanes"}, int'(dq_ovr), hi ? 255 : 0);
        chk(dqs_ovr == hi, {req, " strobe"}, int'(dqs_ovr), int'(hi));
        chk(dqs_n_ovr == !hi, {req, " strobe complement"}, int'(dqs_n_ovr), int'(!hi));
    endtask

    // Burst of four beats; b[0] is the first beat. Junk beats during the
    // write-latency window (R6) and stray beats after the burst (R7).
    task automatic burst(input logic [3:0] b, input bit gaps, input bit model_on);
        int fu, fd;
        mrs(3'b100);
        repeat (WL) begin
            dq_beat_vld = 1'b1;
            dq_in = DQ_W'($urandom);
            tick();
        end
        for (int i = 0; i < 4; i++) begin
            if (gaps) begin
                repeat ($urandom % 3) begin
                    dq_beat_vld = 1'b0;
                    dq_in = DQ_W'($urandom);
                    tick();
                end
            end
            dq_beat_vld = 1'b1;
            dq_in = {DQ_W{b[i]}};
            tick();
        end
        dq_beat_vld = 1'b0;
        if (model_on) begin
            fu = {b[0], b[1]};
            fd = {b[2], b[3]};
            if (fu != 3 && fd != 3) begin
                exp_pu = step_model(exp_pu, fu);
                exp_pd = step_model(exp_pd, fd);
            end
        end
        chk_codes("R6 R7 R8 R9 after burst");
        for (int i = 0; i < 4; i++) begin
            dq_beat_vld = 1'b1;
            dq_in = {DQ_W{i[0]}};
            tick();
        end
        dq_beat_vld = 1'b0;
        chk_codes("R7 second burst ignored");
        mrs(3'b000);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk_codes("R1");
        chk(ovr_en == 1'b0, "R1 override enable", int'(ovr_en), 0);
        chk(bl_err == 1'b0, "R1 error flag", int'(bl_err), 0);

        // R3 drive-high with settle delay
        mrs(3'b001);
        repeat (TOIT - 1) tick();
        chk(ovr_en == 1'b0, "R3 before settle", int'(ovr_en), 0);
        tick();
        chk_levels("R3", 1'b1);
        // R5 other writes ignored while forcing
        mrs(3'b010);
        mrs(3'b111);
        repeat (TOIT + 1) tick();
        chk_levels("R5 persist", 1'b1);
        chk_codes("R5 default ignored");
        mrs(3'b000);
        chk(ovr_en == 1'b0, "R5 exit", int'(ovr_en), 0);

        // R4 drive-low
        mrs(3'b010);
        repeat (TOIT - 1) tick();
        chk(ovr_en == 1'b0, "R4 before settle", int'(ovr_en), 0);
        tick();
        chk_levels("R4", 1'b0);
        mrs(3'b000);
        chk(ovr_en == 1'b0, "R5 exit after drive-low", int'(ovr_en), 0);

        // R2 undefined codes are ignored
        mrs(3'b011);
        mrs(3'b101);
        mrs(3'b110);
        repeat (TOIT + 2) tick();
        chk(ovr_en == 1'b0, "R2 undefined mode", int'(ovr_en), 0);
        chk_codes("R2 undefined mode");

        // R11 adjust without burst length 4
        bl4_cfg = 1'b0;
        burst(4'b0101, 1'b0, 1'b0);
        chk(bl_err == 1'b0, "R11 flag cleared by exit", int'(bl_err), 0);
        mrs(3'b100);
        chk(bl_err == 1'b1, "R11 flag raised", int'(bl_err), 1);
        mrs(3'b000);
        bl4_cfg = 1'b1;

        // R8 saturate pull-up high (beats 0,1 = 0,1) and pull-down low (beats 2,3 = 1,0)
        repeat (9) burst(4'b0110, 1'b1, 1'b1);
        chk(int'(pu_code) == TOP, "R8 pull-up top", int'(pu_code), TOP);
        repeat (9) burst(4'b0110, 1'b0, 1'b1);
        chk(int'(pd_code) == 0, "R8 pull-down bottom", int'(pd_code), 0);

        // R9 reserved field
        burst(4'b1100, 1'b0, 1'b1);
        burst(4'b1111, 1'b1, 1'b1);

        // R10 default reload
        mrs(3'b111);
        exp_pu = DEF;
        exp_pd = DEF;
        chk_codes("R10 reload");

        // Random bursts
        for (int n = 0; n < 40; n++) begin
            burst(4'($urandom), 1'b1, 1'b1);
        end
        mrs(3'b111);
        exp_pu = DEF;
        exp_pd = DEF;
        chk_codes("R10 final reload");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule